// File: doc/BRIEF.md
# Acquisition Trigger Controller

This block is the trigger front end of a six-channel acquisition engine. The host writes 16-bit words into two registers and can read them back. One register holds the interrupt service level. The other holds three things:

- one software trigger bit per channel;
- a source selector for the two high-speed channels;
- the edge polarity used for the external trigger input.

Each channel has an arm input from the acquisition engine. A channel's trigger output can pulse only while that channel is armed.

Software triggers on channels 0 to 3 come only from their own force bits. Channels 4 and 5 also have their own force bits. In addition, they follow a shared source. That source is either the trigger fired by one of channels 0 to 3 in the same cycle, or an edge on the external trigger input. The external input is synchronised before its edge is detected. Every trigger leaves the block as a one-cycle pulse.

Top module: `acq_trig_ctrl`

## Requirements
- R1: Channel i triggers when control bit 6+i changes from 0 to 1 through a write to offset 0x02 while arm[i] is high. The write is taken at clock edge k, and trig_out[i] is high for the cycle after edge k+1.
- R2: A force bit that is written 1 again while already 1 gives no further trigger. It must be written 0 and then 1 again to trigger once more.
- R3: A channel whose arm input is low never pulses. A force rise that occurs while the channel is unarmed is lost.
- R4: Several force bits rising in one write trigger all their armed channels in the same cycle.
- R5: Control bits 15:13 hold the high-speed source code. Codes 000 to 011 make channels 4 and 5 pulse in the same cycle as channel 0 to 3 respectively fires. The high-speed channel must itself be armed.
- R6: Source code 110 selects the external input, and control bit 12 picks its edge: 0 is rising, 1 is falling. The input passes through a two-stage synchroniser. A change driven before clock edge e1 gives a pulse in the cycle after edge e3.
- R7: Source codes 100, 101 and 111 give no source-driven triggers. Force bits 10 and 11 still trigger channels 4 and 5.
- R8: A write to offset 0x00 stores bits 2:0 as the interrupt level on irq_level. The value 0 means no interrupt and 1 to 7 select that level.
- R9: rd_data returns the following, depending on offset:
  - at offset 0x00, the last level written, in bits 2:0;
  - at offset 0x02, the last control word written, with bits 5:0 read as 0;
  - at any other offset, 0.
- R10: A synchronous active-low reset clears both registers, the force history and the synchroniser. The first force write after reset can therefore trigger.
- R11: Trigger outputs are single-cycle pulses. A channel among 0 to 3 never pulses in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W (8) | Register offset for write and readback |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Readback of the register at addr (combinational) |
| arm | input | 6 | Per-channel armed state |
| ext_trig | input | 1 | External trigger, asynchronous |
| trig_out | output | 6 | Per-channel trigger pulses |
| irq_level | output | 3 | Stored interrupt level |

## Verification
The assertions assume the following about the inputs:

- wr_en, addr, wr_data and arm are synchronous to clk.
- ext_trig is the only input allowed to change with no relation to the clock.
- Reset is held low for at least one clock edge before checking begins.

The bench drives every input on the falling edge. It keeps the bus fields stable across each write edge. Reset is asserted at time zero, and once more mid-run.

Randomised traffic mixes writes to both registers and to unmapped offsets with toggling arm and external inputs. This covers the valid and invalid source codes and both edge polarities, and stays inside these assumptions.

// File: rtl/acq_trig_pkg.sv
// Shared constants, the control word layout and a source-code helper
// for the acquisition trigger controller.
// Assumes six channels, the last two being the high-speed ones.
package acq_trig_pkg;

    localparam int DATA_W    = 16;
    localparam int CH_N      = 6;
    localparam int HS_FIRST  = 4;   // channels below this are low-speed
    localparam int LVL_W     = 3;
    localparam int SEL_W     = 3;
    localparam int FORCE_LSB = 6;
    localparam int RSVD_W    = FORCE_LSB;
    localparam logic [SEL_W-1:0] SRC_EXT = 3'b110;

    // Control word, most significant field first
    typedef struct packed {
        logic [SEL_W-1:0] src_sel;     // bits 15:13
        logic             ext_neg;     // bit 12
        logic [CH_N-1:0]  force_bits;  // bits 11:6
        logic [RSVD_W-1:0] rsvd;       // bits 5:0, always zero
    } ctrl_t;

    // True when the source code selects a real trigger source
    function automatic logic src_valid(input logic [SEL_W-1:0] sel);
        return (sel[SEL_W-1] == 1'b0) || (sel == SRC_EXT);
    endfunction

endpackage

// File: rtl/trig_regs.sv
// Host register file: the level register and the control register, with
// combinational readback.
// Assumes a single-cycle wr_en strobe with addr and wr_data stable at the edge.
module trig_regs
    import acq_trig_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LVL_ADDR  = 0,
    parameter int CTRL_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [LVL_W-1:0]  level,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] LVL_A  = ADDR_W'(LVL_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [DATA_W-1:0] CTRL_MASK = {{(DATA_W-RSVD_W){1'b1}}, {RSVD_W{1'b0}}};

    ctrl_t             ctrl_q;
    logic [LVL_W-1:0]  level_q;

    // Purpose: capture host writes into the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            level_q <= '0;
        end else if (wr_en) begin
            if (addr == LVL_A)
                level_q <= wr_data[LVL_W-1:0];
            if (addr == CTRL_A)
                ctrl_q <= ctrl_t'(wr_data & CTRL_MASK);
        end
    end

    // Purpose: select the readback word, zero for unmapped offsets
    always_comb begin
        rd_data = '0;
        if (addr == LVL_A)
            rd_data = {{(DATA_W-LVL_W){1'b0}}, level_q};
        else if (addr == CTRL_A)
            rd_data = DATA_W'(ctrl_q);
    end

    assign ctrl  = ctrl_q;
    assign level = level_q;

endmodule

// File: rtl/trig_ext_sync.sv
// Synchronises the asynchronous external trigger and flags one edge of the
// chosen polarity for one cycle.
// Assumes that ext_in may change at any time.
module trig_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic falling,
    output logic edge_hit
);
    // hist[STAGES-1] is the synchronised level, hist[STAGES] its previous value
    logic [STAGES:0] hist_q;

    // Purpose: shift the input through the synchroniser and edge history
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= {hist_q[STAGES-1:0], ext_in};
    end

    // Purpose: pick the rising or the falling transition of the synced level
    always_comb begin
        if (falling)
            edge_hit = hist_q[STAGES] & ~hist_q[STAGES-1];
        else
            edge_hit = hist_q[STAGES-1] & ~hist_q[STAGES];
    end

endmodule

// File: rtl/trig_fire.sv
// Detects rising force bits, selects the high-speed source and registers
// the per-channel trigger pulses, all gated by the arm inputs.
// Assumes that source codes 0..3 address the HS_FIRST low-speed channels.
module trig_fire
    import acq_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  force_bits,
    input  logic [CH_N-1:0]  arm,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             ext_edge,
    output logic [CH_N-1:0]  force_rise,
    output logic [CH_N-1:0]  trig_out
);
    logic [CH_N-1:0]     force_prev_q;
    logic [CH_N-1:0]     trig_next;
    logic [CH_N-1:0]     trig_q;
    logic [HS_FIRST-1:0] lo_fire;
    logic                src_hit;

    // Purpose: remember last cycle's force bits for 0-to-1 detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_prev_q <= '0;
        else
            force_prev_q <= force_bits;
    end

    assign force_rise = force_bits & ~force_prev_q;
    assign lo_fire    = force_rise[HS_FIRST-1:0] & arm[HS_FIRST-1:0];

    // Purpose: choose the shared source for the high-speed channels
    always_comb begin
        if (src_sel[SEL_W-1] == 1'b0)
            src_hit = lo_fire[src_sel[1:0]];
        else if (src_sel == SRC_EXT)
            src_hit = ext_edge;
        else
            src_hit = 1'b0;
    end

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        if (i < HS_FIRST) begin : g_lo
            assign trig_next[i] = force_rise[i] & arm[i];
        end else begin : g_hs
            assign trig_next[i] = (force_rise[i] | src_hit) & arm[i];
        end
    end

    // Purpose: register the trigger pulses
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else
            trig_q <= trig_next;
    end

    assign trig_out = trig_q;

endmodule

// File: rtl/acq_trig_ctrl.sv
// Top of the acquisition trigger controller: register file, external trigger
// synchroniser and per-channel trigger generation.
// Assumes the host bus is synchronous to clk; ext_trig may be asynchronous.
module acq_trig_ctrl
    import acq_trig_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int LVL_ADDR    = 0,
    parameter int CTRL_ADDR   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic [5:0]        arm,
    input  logic              ext_trig,
    output logic [5:0]        trig_out,
    output logic [2:0]        irq_level
);
    ctrl_t           ctrl_w;
    logic            ext_edge_w;
    logic [CH_N-1:0] force_rise_w;

    trig_regs #(
        .ADDR_W    (ADDR_W),
        .LVL_ADDR  (LVL_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .ctrl    (ctrl_w),
        .level   (irq_level),
        .rd_data (rd_data)
    );

    trig_ext_sync #(
        .STAGES (SYNC_STAGES)
    ) ext_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_trig),
        .falling  (ctrl_w.ext_neg),
        .edge_hit (ext_edge_w)
    );

    trig_fire fire_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_bits (ctrl_w.force_bits),
        .arm        (arm),
        .src_sel    (ctrl_w.src_sel),
        .ext_edge   (ext_edge_w),
        .force_rise (force_rise_w),
        .trig_out   (trig_out)
    );

endmodule

// File: rtl/acq_trig_chk.sv
// Property checker for acq_trig_ctrl, attached by bind.
// Assumes bus inputs and arm are synchronous to clk.
module acq_trig_chk
    import acq_trig_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LVL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [LVL_W-1:0]  lvl_data,
    input logic [CH_N-1:0]   arm,
    input logic [CH_N-1:0]   trig_out,
    input logic [LVL_W-1:0]  irq_level,
    input logic [CH_N-1:0]   force_bits,
    input logic [CH_N-1:0]   force_rise,
    input logic [SEL_W-1:0]  src_sel
);
    // R1: a low-speed pulse needs its force bit set at the previous edge
    assert_force_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_out[HS_FIRST-1:0]) |->
            ((trig_out[HS_FIRST-1:0] & ~$past(force_bits[HS_FIRST-1:0])) == '0));

    // R3: no pulse on a channel that was not armed
    assert_armed_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_out) |-> ((trig_out & ~$past(arm)) == '0));

    // R7: high-speed pulses under an invalid code come only from force rises
    assert_invalid_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_out[CH_N-1:HS_FIRST]) |->
            (src_valid($past(src_sel)) || ($past(force_rise[CH_N-1:HS_FIRST]) != '0)));

    // R8: a level write appears on irq_level one cycle later
    assert_level_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(LVL_ADDR)) |=> (irq_level == $past(lvl_data)));

    // R10: reset clears outputs and force bits
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (trig_out == '0 && irq_level == '0 && force_bits == '0));

    // R11: low-speed channels never pulse twice in a row
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_out[HS_FIRST-1:0]) |=>
            ((trig_out[HS_FIRST-1:0] & $past(trig_out[HS_FIRST-1:0])) == '0));

endmodule

bind acq_trig_ctrl acq_trig_chk #(
    .ADDR_W   (ADDR_W),
    .LVL_ADDR (LVL_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .lvl_data   (wr_data[2:0]),
    .arm        (arm),
    .trig_out   (trig_out),
    .irq_level  (irq_level),
    .force_bits (ctrl_w.force_bits),
    .force_rise (force_rise_w),
    .src_sel    (ctrl_w.src_sel)
);

// File: tb/acq_trig_ctrl_tb_top.sv
// Bench for acq_trig_ctrl: a behavioural reference model compared every cycle,
// plus directed checks with hand-computed expectations.
module acq_trig_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;
    logic [5:0]  arm = 6'h00;
    logic        ext_trig = 1'b0;
    logic [5:0]  trig_out;
    logic [2:0]  irq_level;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R10";
    bit    started  = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    acq_trig_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .arm       (arm),
        .ext_trig  (ext_trig),
        .trig_out  (trig_out),
        .irq_level (irq_level)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_ctrl;
    logic [2:0]  m_lvl;
    logic [5:0]  m_prev;
    logic [5:0]  m_trig;
    bit          ext_hist[$];   // [0] newest sample

    initial begin
        m_ctrl = '0; m_lvl = '0; m_prev = '0; m_trig = '0;
        ext_hist = '{0, 0, 0};
    end

    always @(posedge clk) begin
        logic [5:0] rise, fire;
        logic       edge_seen, src;
        int         sel;
        started = 1'b1;
        if (!rst_n) begin
            m_ctrl = '0; m_lvl = '0; m_prev = '0; m_trig = '0;
            ext_hist = '{0, 0, 0};
        end else begin
            rise = m_ctrl[11:6] & ~m_prev;
            fire = rise & arm;
            if (m_ctrl[12])
                edge_seen = !ext_hist[1] && ext_hist[2];
            else
                edge_seen = ext_hist[1] && !ext_hist[2];
            sel = int'(m_ctrl[15:13]);
            if (sel < 4)       src = fire[sel];
            else if (sel == 6) src = edge_seen;
            else               src = 1'b0;
            m_trig = fire;
            m_trig[4] = fire[4] | (src & arm[4]);
            m_trig[5] = fire[5] | (src & arm[5]);
            m_prev = m_ctrl[11:6];
            ext_hist.push_front(ext_trig);
            void'(ext_hist.pop_back());
            if (wr_en) begin
                if (addr == 8'h00) m_lvl  = wr_data[2:0];
                if (addr == 8'h02) m_ctrl = wr_data & 16'hFFC0;
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [7:0] a);
        if (a == 8'h00) return {13'd0, m_lvl};
        if (a == 8'h02) return m_ctrl;
        return 16'h0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(trig_out === m_trig, cur_req, "trig_out", 16'(trig_out), 16'(m_trig));
            check(irq_level === m_lvl, cur_req, "irq_level", 16'(irq_level), 16'(m_lvl));
            check(rd_data === model_rd(addr), cur_req, "rd_data", rd_data, model_rd(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_reg(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h02;
    endtask

    // After write_reg returns, the pulse is visible at the next falling edge
    task automatic expect_trig(input logic [5:0] exp, input string req);
        @(negedge clk);
        check(trig_out === exp, req, "directed trig_out", 16'(trig_out), 16'(exp));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        check(trig_out === 6'h00 && irq_level === 3'd0, "R10", "reset outputs",
              {7'd0, irq_level, trig_out}, 16'h0000);
        addr = 8'h02;
        check(rd_data === 16'h0000, "R10", "reset readback", rd_data, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        arm   = 6'h3F;

        // R1 with R5: ch0 force rise, source 000 mirrors ch0 onto ch4 and ch5
        cur_req = "R1";
        write_reg(8'h02, 16'h0040);
        expect_trig(6'b110001, "R1");
        expect_trig(6'b000000, "R11");

        // R2: bit held at 1 gives nothing; 0 then 1 gives a new pulse
        cur_req = "R2";
        write_reg(8'h02, 16'h0040);
        expect_trig(6'b000000, "R2");
        write_reg(8'h02, 16'h0000);
        write_reg(8'h02, 16'h0040);
        expect_trig(6'b110001, "R2");

        // R5: source 010 follows ch2
        cur_req = "R5";
        write_reg(8'h02, 16'h4000);
        write_reg(8'h02, 16'h4100);
        expect_trig(6'b110100, "R5");

        // R4 with R7: invalid code 100, all force bits rise together
        cur_req = "R4";
        write_reg(8'h02, 16'h8000);
        write_reg(8'h02, 16'h8FC0);
        expect_trig(6'b111111, "R4");
        cur_req = "R7";
        write_reg(8'h02, 16'hE000);
        write_reg(8'h02, 16'hE040);
        expect_trig(6'b000001, "R7");

        // R3: ch0 unarmed, its rise is lost and nothing mirrors
        cur_req = "R3";
        write_reg(8'h02, 16'h0000);
        arm = 6'h3E;
        write_reg(8'h02, 16'h0040);
        expect_trig(6'b000000, "R3");
        arm = 6'h3F;
        expect_trig(6'b000000, "R3");

        // R6: external rising edge, then falling polarity
        cur_req = "R6";
        write_reg(8'h02, 16'hC000);
        @(negedge clk);
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        check(trig_out === 6'b110000, "R6", "ext rising", 16'(trig_out), 16'h0030);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        check(trig_out === 6'b000000, "R6", "falling ignored in rising mode", 16'(trig_out), 16'h0000);
        write_reg(8'h02, 16'hD000);
        ext_trig = 1'b1;
        repeat (4) @(negedge clk);
        ext_trig = 1'b0;
        repeat (3) @(negedge clk);
        check(trig_out === 6'b110000, "R6", "ext falling", 16'(trig_out), 16'h0030);

        // R8 and R9: level and readback
        cur_req = "R8";
        write_reg(8'h00, 16'hFFFD);
        check(irq_level === 3'd5, "R8", "level", 16'(irq_level), 16'h0005);
        addr = 8'h00;
        @(negedge clk);
        check(rd_data === 16'h0005, "R9", "level readback", rd_data, 16'h0005);
        cur_req = "R9";
        write_reg(8'h02, 16'hFFFF);
        @(negedge clk);
        check(rd_data === 16'hFFC0, "R9", "ctrl readback", rd_data, 16'hFFC0);
        addr = 8'h05;
        @(negedge clk);
        check(rd_data === 16'h0000, "R9", "unmapped readback", rd_data, 16'h0000);
        write_reg(8'h00, 16'h0000);
        check(irq_level === 3'd0, "R8", "level zero", 16'(irq_level), 16'h0000);

        // R10: mid-run reset, then first write triggers
        cur_req = "R10";
        write_reg(8'h02, 16'h0040);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        write_reg(8'h02, 16'h0040);
        expect_trig(6'b110001, "R10");

        // Random traffic compared every cycle against the model
        cur_req = "R9_random";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 3) == 0;
            case ($urandom % 3)
                0: addr = 8'h00;
                1: addr = 8'h02;
                default: addr = 8'h07;
            endcase
            wr_data = 16'($urandom);
            if (($urandom % 4) == 0) arm = 6'($urandom);
            if (($urandom % 3) == 0) ext_trig = ~ext_trig;
        end
        @(negedge clk);
        wr_en = 1'b0;
        repeat (4) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule